// File: doc/BRIEF.md
# Stacked Register Frame Renamer

This block turns the register numbers written in instructions into physical register indices for a machine whose procedures each own a variable-size window of stacked registers. Numbers below 32 name a fixed set of registers and pass straight through. Numbers 32 and above are relative to the window of the running procedure. They are remapped through a rotating base pointer into a pool of 96 physical registers.

The block keeps a frame marker for the running procedure and one saved marker for its caller. The marker holds a window size and a locals size. Three single-cycle commands update the markers:

- A call hands the caller's outgoing registers to the callee, so that they appear from register 32 upward in the callee.
- An allocate resizes the window from input, local and output counts.
- A return brings back the caller's window and numbering.

A usage counter tracks how much of the pool is held. It pulses a request when the pool is oversubscribed, so that a separate engine can move registers out to memory.

Top module: `frm_renamer`

## Requirements
- R1: A lookup of a register number below 32 returns that same number as the physical index and never flags an illegal access.
- R2: A lookup of register v, with 32 <= v < 32 + window size, returns 32 + ((base + v - 32) mod 96). The base is 0 after reset.
- R3: A lookup of register v >= 32 + window size drives the illegal flag to 1 and the physical index to 0.
- R4: An accepted allocate with counts i, l and o sets the window size to i+l+o and the locals size to i+l from the next cycle on. It leaves the base unchanged. The locals size never exceeds the window size.
- R5: An allocate whose total i+l+o exceeds 96 has no effect on the markers, the base or the usage count.
- R6: A call copies the current marker into the saved marker and shrinks the window size by the locals size. It sets the locals size to 0 and advances the base by the old locals size, modulo 96. As a result, the caller's register 32+sol+k becomes the callee's register 32+k.
- R7: A return loads the current marker from the saved marker and moves the base back by the saved locals size, modulo 96. The caller's numbering is then restored.
- R8: When several command strobes are high in the same cycle, only one takes effect. Call wins over allocate, and allocate wins over return.
- R9: The usage count is the locals held by ancestor frames plus the current window size. A call leaves it unchanged. `ovf_req_o` is high for exactly the one cycle after an accepted allocate that leaves the count above 96, and is low otherwise.
- R10: After reset, both markers are zero, the base is 0 and `ovf_req_o` is low. Every register from 32 upward is then illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Call command strobe |
| alloc_i | input | 1 | Allocate command strobe |
| ret_i | input | 1 | Return command strobe |
| in_cnt_i | input | 7 | Input register count for allocate |
| loc_cnt_i | input | 7 | Local register count for allocate |
| out_cnt_i | input | 7 | Output register count for allocate |
| lk_vreg_i | input | 7 | Register number to look up |
| lk_pidx_o | output | 7 | Physical register index (combinational) |
| lk_illegal_o | output | 1 | Lookup falls outside the current window |
| ovf_req_o | output | 1 | One-cycle request to free pool space |

## Verification
The checker watches every cycle for the following:
- static registers pass through unchanged;
- an illegal lookup returns index zero;
- every legal stacked index falls inside the pool;
- the locals size stays within the window size;
- each command applies its marker update one cycle later, with a rejected allocate leaving the markers stable.

The modular base arithmetic cannot be seen through these per-cycle relations, and neither can the usage count behind the overflow pulse. For those, the bench uses sequences of calls, allocates and returns with full sweeps of all 128 register numbers. These sequences include windows that wrap around the end of the pool and strobes raised together.

// File: rtl/frm_pkg.sv
package frm_pkg;
   localparam int MARK_W = 8;

   typedef struct packed {
      logic [MARK_W-1:0] sof;
      logic [MARK_W-1:0] sol;
   } frame_mark_t;

   typedef enum logic [1:0] {
      CMD_NONE,
      CMD_CALL,
      CMD_ALLOC,
      CMD_RET
   } frame_cmd_e;
endpackage

// File: rtl/frm_marker.sv
module frm_marker
   import frm_pkg::*;
#(
   parameter int POOL  = 96,
   parameter int TOT_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  frame_cmd_e        cmd,
   input  logic              alloc_ok,
   input  logic [TOT_W-1:0]  tot,
   input  logic [TOT_W-1:0]  inloc,
   output frame_mark_t       cur_o,
   output frame_mark_t       sav_o,
   output logic [MARK_W-1:0] base_o
);
   localparam logic [MARK_W:0] POOL_E = (MARK_W+1)'(POOL);

   frame_mark_t       cur_q, sav_q;
   logic [MARK_W-1:0] base_q;
   logic [MARK_W:0]   up_sum, dn_sum;
   logic [MARK_W-1:0] base_up, base_dn;

   always_comb begin
      up_sum  = {1'b0, base_q} + {1'b0, cur_q.sol};
      dn_sum  = {1'b0, base_q} + POOL_E - {1'b0, sav_q.sol};
      base_up = (up_sum >= POOL_E) ? MARK_W'(up_sum - POOL_E) : up_sum[MARK_W-1:0];
      base_dn = (dn_sum >= POOL_E) ? MARK_W'(dn_sum - POOL_E) : dn_sum[MARK_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         sav_q  <= '0;
         base_q <= '0;
      end else begin
         unique case (cmd)
            CMD_CALL: begin
               sav_q     <= cur_q;
               cur_q.sof <= cur_q.sof - cur_q.sol;
               cur_q.sol <= '0;
               base_q    <= base_up;
            end
            CMD_ALLOC: begin
               if (alloc_ok) begin
                  cur_q.sof <= MARK_W'(tot);
                  cur_q.sol <= MARK_W'(inloc);
               end
            end
            CMD_RET: begin
               cur_q  <= sav_q;
               base_q <= base_dn;
            end
            default: ;
         endcase
      end
   end

   assign cur_o  = cur_q;
   assign sav_o  = sav_q;
   assign base_o = base_q;
endmodule

// File: rtl/frm_usage.sv
module frm_usage
   import frm_pkg::*;
#(
   parameter int POOL  = 96,
   parameter int TOT_W = 9,
   parameter int USE_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  frame_cmd_e       cmd,
   input  logic             alloc_ok,
   input  logic [TOT_W-1:0] tot,
   input  frame_mark_t      cur,
   input  frame_mark_t      sav,
   output logic             ovf_req_o
);
   localparam int EXT = USE_W + 2;
   typedef logic signed [EXT-1:0] sw_t;

   logic [USE_W-1:0] used_q;
   sw_t              calc;
   logic             upd;

   always_comb begin
      calc = sw_t'(used_q);
      upd  = 1'b0;
      if (cmd == CMD_ALLOC && alloc_ok) begin
         calc = sw_t'(used_q) + sw_t'(tot) - sw_t'(cur.sof);
         upd  = 1'b1;
      end else if (cmd == CMD_RET) begin
         calc = sw_t'(used_q) - sw_t'(cur.sof) - sw_t'(sav.sol) + sw_t'(sav.sof);
         upd  = 1'b1;
      end
      if (calc < 0) calc = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_q    <= '0;
         ovf_req_o <= 1'b0;
      end else begin
         if (upd) used_q <= USE_W'(calc);
         ovf_req_o <= (cmd == CMD_ALLOC) && alloc_ok && (calc > sw_t'(POOL));
      end
   end
endmodule

// File: rtl/frm_xlate.sv
module frm_xlate
   import frm_pkg::*;
#(
   parameter int NUM_STATIC = 32,
   parameter int POOL       = 96,
   parameter int VREG_W     = 7,
   parameter int PIDX_W     = 7
) (
   input  logic [VREG_W-1:0] vreg,
   input  logic [MARK_W-1:0] sof,
   input  logic [MARK_W-1:0] base,
   output logic [PIDX_W-1:0] pidx,
   output logic              illegal
);
   localparam logic [VREG_W-1:0] STAT_V = VREG_W'(NUM_STATIC);
   localparam logic [MARK_W:0]   POOL_E = (MARK_W+1)'(POOL);
   localparam bit                POW2   = (POOL & (POOL - 1)) == 0;

   logic [VREG_W-1:0] off;
   logic [MARK_W:0]   sum;
   logic [MARK_W-1:0] slot;

   assign off = vreg - STAT_V;
   assign sum = {1'b0, base} + (MARK_W+1)'(off);

   generate
      if (POW2) begin : g_mask
         assign slot = MARK_W'(sum & (POOL_E - 1'b1));
      end else begin : g_sub
         assign slot = (sum >= POOL_E) ? MARK_W'(sum - POOL_E) : sum[MARK_W-1:0];
      end
   endgenerate

   always_comb begin
      illegal = 1'b0;
      pidx    = '0;
      if (vreg < STAT_V) begin
         pidx = PIDX_W'(vreg);
      end else if ((MARK_W+1)'(off) >= {1'b0, sof}) begin
         illegal = 1'b1;
      end else begin
         pidx = PIDX_W'(NUM_STATIC) + PIDX_W'(slot);
      end
   end
endmodule

// File: rtl/frm_renamer.sv
module frm_renamer
   import frm_pkg::*;
#(
   parameter int NUM_VREG   = 128,
   parameter int NUM_STATIC = 32,
   parameter int POOL       = 96,
   parameter int CNT_W      = 7,
   parameter int USE_W      = 12,
   localparam int VREG_W    = $clog2(NUM_VREG),
   localparam int PIDX_W    = $clog2(NUM_STATIC + POOL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_i,
   input  logic              alloc_i,
   input  logic              ret_i,
   input  logic [CNT_W-1:0]  in_cnt_i,
   input  logic [CNT_W-1:0]  loc_cnt_i,
   input  logic [CNT_W-1:0]  out_cnt_i,
   input  logic [VREG_W-1:0] lk_vreg_i,
   output logic [PIDX_W-1:0] lk_pidx_o,
   output logic              lk_illegal_o,
   output logic              ovf_req_o
);
   localparam int TOT_W = CNT_W + 2;

   generate
      if (NUM_STATIC + POOL != NUM_VREG) begin : g_bad_split
         $error("static count plus pool must equal the register space");
      end
      if (POOL >= (1 << MARK_W)) begin : g_bad_pool
         $error("pool does not fit the marker fields");
      end
      if ((1 << USE_W) <= 2 * POOL) begin : g_bad_use
         $error("usage counter too narrow");
      end
   endgenerate

   frame_cmd_e        cmd;
   logic [TOT_W-1:0]  alloc_total, alloc_inloc;
   logic              alloc_ok;
   frame_mark_t       cur_mark, sav_mark;
   logic [MARK_W-1:0] base;

   always_comb begin
      if (call_i)       cmd = CMD_CALL;
      else if (alloc_i) cmd = CMD_ALLOC;
      else if (ret_i)   cmd = CMD_RET;
      else              cmd = CMD_NONE;
   end

   assign alloc_inloc = TOT_W'(in_cnt_i) + TOT_W'(loc_cnt_i);
   assign alloc_total = alloc_inloc + TOT_W'(out_cnt_i);
   assign alloc_ok    = alloc_total <= TOT_W'(POOL);

   frm_marker #(.POOL(POOL), .TOT_W(TOT_W)) u_marker (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .alloc_ok (alloc_ok),
      .tot      (alloc_total),
      .inloc    (alloc_inloc),
      .cur_o    (cur_mark),
      .sav_o    (sav_mark),
      .base_o   (base)
   );

   frm_usage #(.POOL(POOL), .TOT_W(TOT_W), .USE_W(USE_W)) u_usage (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .alloc_ok  (alloc_ok),
      .tot       (alloc_total),
      .cur       (cur_mark),
      .sav       (sav_mark),
      .ovf_req_o (ovf_req_o)
   );

   frm_xlate #(
      .NUM_STATIC (NUM_STATIC),
      .POOL       (POOL),
      .VREG_W     (VREG_W),
      .PIDX_W     (PIDX_W)
   ) u_xlate (
      .vreg    (lk_vreg_i),
      .sof     (cur_mark.sof),
      .base    (base),
      .pidx    (lk_pidx_o),
      .illegal (lk_illegal_o)
   );
endmodule

// File: rtl/frm_renamer_chk.sv
module frm_renamer_chk
   import frm_pkg::*;
#(
   parameter int NUM_STATIC = 32,
   parameter int POOL       = 96,
   parameter int VREG_W     = 7,
   parameter int PIDX_W     = 7,
   parameter int TOT_W      = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              call_i,
   input logic              alloc_i,
   input logic              ret_i,
   input logic [TOT_W-1:0]  total,
   input logic              alloc_ok,
   input logic [MARK_W-1:0] cur_sof,
   input logic [MARK_W-1:0] cur_sol,
   input logic [MARK_W-1:0] sav_sof,
   input logic [MARK_W-1:0] sav_sol,
   input logic [VREG_W-1:0] lk_vreg,
   input logic [PIDX_W-1:0] lk_pidx,
   input logic              lk_illegal
);
   localparam logic [VREG_W-1:0] STAT_V = VREG_W'(NUM_STATIC);
   localparam logic [PIDX_W:0]   STAT_P = (PIDX_W+1)'(NUM_STATIC);
   localparam logic [PIDX_W:0]   END_P  = (PIDX_W+1)'(NUM_STATIC + POOL);

   AST_STATIC_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_vreg < STAT_V) |-> (lk_pidx == PIDX_W'(lk_vreg) && !lk_illegal)); // R1

   AST_STACKED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_vreg >= STAT_V && !lk_illegal) |-> ({1'b0, lk_pidx} >= STAT_P && {1'b0, lk_pidx} < END_P)); // R2

   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lk_illegal |-> (lk_pidx == '0)); // R3

   AST_ALLOC_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_i && !call_i && alloc_ok) |=> (cur_sof == MARK_W'($past(total)))); // R4

   AST_SOL_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
      cur_sol <= cur_sof); // R4

   AST_ALLOC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_i && !call_i && !alloc_ok) |=> ($stable(cur_sof) && $stable(cur_sol))); // R5

   AST_CALL_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
      call_i |=> (cur_sol == '0 && cur_sof == $past(cur_sof) - $past(cur_sol))); // R6

   AST_CALL_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      call_i |=> (sav_sof == $past(cur_sof) && sav_sol == $past(cur_sol))); // R6

   AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !call_i && !alloc_i) |=> (cur_sof == $past(sav_sof) && cur_sol == $past(sav_sol))); // R7
endmodule

bind frm_renamer frm_renamer_chk #(
   .NUM_STATIC (NUM_STATIC),
   .POOL       (POOL),
   .VREG_W     (VREG_W),
   .PIDX_W     (PIDX_W),
   .TOT_W      (TOT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .call_i     (call_i),
   .alloc_i    (alloc_i),
   .ret_i      (ret_i),
   .total      (alloc_total),
   .alloc_ok   (alloc_ok),
   .cur_sof    (cur_mark.sof),
   .cur_sol    (cur_mark.sol),
   .sav_sof    (sav_mark.sof),
   .sav_sol    (sav_mark.sol),
   .lk_vreg    (lk_vreg_i),
   .lk_pidx    (lk_pidx_o),
   .lk_illegal (lk_illegal_o)
);

// File: tb/frm_renamer_bench.sv
`timescale 1ns/1ps
module frm_renamer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       call_i = 1'b0, alloc_i = 1'b0, ret_i = 1'b0;
   logic [6:0] in_cnt_i = '0, loc_cnt_i = '0, out_cnt_i = '0;
   logic [6:0] lk_vreg_i = '0;
   logic [6:0] lk_pidx_o;
   logic       lk_illegal_o, ovf_req_o;

   int total = 0, bad = 0;
   bit done = 0;
   int m_sof = 0, m_sol = 0, s_sof = 0, s_sol = 0, m_base = 0, m_used = 0;
   bit exp_ovf = 0;

   always #4 clk = ~clk;

   frm_renamer u_frm_renamer (
      .clk(clk), .rst_n(rst_n), .call_i(call_i), .alloc_i(alloc_i), .ret_i(ret_i),
      .in_cnt_i(in_cnt_i), .loc_cnt_i(loc_cnt_i), .out_cnt_i(out_cnt_i),
      .lk_vreg_i(lk_vreg_i), .lk_pidx_o(lk_pidx_o),
      .lk_illegal_o(lk_illegal_o), .ovf_req_o(ovf_req_o)
   );

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic sweep(string ctx);
      for (int v = 0; v < 128; v++) begin
         int  ep;
         bit  ei;
         string req;
         lk_vreg_i = 7'(v);
         #1;
         if (v < 32) begin
            ep = v; ei = 0; req = "R1";
         end else if (v - 32 >= m_sof) begin
            ep = 0; ei = 1; req = "R3";
         end else begin
            ep = 32 + ((m_base + v - 32) % 96); ei = 0; req = "R2";
         end
         total++;
         if (int'(lk_pidx_o) != ep || lk_illegal_o != ei) begin
            bad++;
            $display("FAIL %s (%s) vreg=%0d pidx=%0d exp=%0d illegal=%0d exp=%0d",
                     req, ctx, v, lk_pidx_o, ep, lk_illegal_o, ei);
         end
      end
   endtask

   task automatic do_cmd(bit c, bit a, bit r, int i, int l, int o, string ctx);
      @(negedge clk);
      call_i = c; alloc_i = a; ret_i = r;
      in_cnt_i = 7'(i); loc_cnt_i = 7'(l); out_cnt_i = 7'(o);
      exp_ovf = 0;
      if (c) begin
         s_sof = m_sof; s_sol = m_sol;
         m_base = (m_base + m_sol) % 96;
         m_sof = m_sof - m_sol; m_sol = 0;
      end else if (a) begin
         if (i + l + o <= 96) begin
            int nu = m_used + i + l + o - m_sof;
            exp_ovf = nu > 96;
            m_used = nu; m_sof = i + l + o; m_sol = i + l;
         end
      end else if (r) begin
         int nu = m_used - m_sof - s_sol + s_sof;
         if (nu < 0) nu = 0;
         m_used = nu;
         m_base = (m_base + 96 - s_sol) % 96;
         m_sof = s_sof; m_sol = s_sol;
      end
      @(negedge clk);
      call_i = 0; alloc_i = 0; ret_i = 0;
      total++;
      if (ovf_req_o != exp_ovf) begin
         bad++;
         $display("FAIL R9 (%s) ovf_req=%0d exp=%0d", ctx, ovf_req_o, exp_ovf);
      end
      sweep(ctx);
      @(negedge clk);
      total++;
      if (ovf_req_o != 1'b0) begin
         bad++;
         $display("FAIL R9 (%s) pulse too long ovf_req=%0d exp=0", ctx, ovf_req_o);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired got=running exp=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      total++;
      if (ovf_req_o != 1'b0) begin
         bad++;
         $display("FAIL R10 reset ovf_req=%0d exp=0", ovf_req_o);
      end
      sweep("R10 reset");
      do_cmd(0, 1, 0, 3, 11, 7, "R4 alloc 21/14");
      do_cmd(1, 0, 0, 0, 0, 0, "R6 call");
      do_cmd(0, 1, 0, 7, 9, 3, "R4 alloc 19/16");
      do_cmd(1, 0, 0, 0, 0, 0, "R6 nested call");
      do_cmd(0, 0, 1, 0, 0, 0, "R7 return");
      do_cmd(0, 1, 0, 40, 40, 17, "R5 oversize alloc");
      do_cmd(0, 1, 0, 30, 30, 36, "R9 full pool alloc wraps");
      do_cmd(1, 1, 0, 1, 1, 1, "R8 call beats alloc");
      do_cmd(0, 1, 1, 2, 2, 2, "R8 alloc beats return");
      do_cmd(0, 0, 1, 0, 0, 0, "R7 return after wrap");
      do_cmd(0, 1, 0, 0, 0, 5, "R9 shrink no request");
      finish_run();
   end
endmodule